// File: doc/BRIEF.md
# Prescaled Cycle/Scanline Interrupt Timer

This block is an 8-bit up-counting interrupt timer. It sits beside a CPU and advances on a one-cycle CPU strobe. It has two time bases. In cycle mode every enabled CPU cycle advances the count. In scanline mode a signed subtractive prescaler approximates display lines from CPU cycles: it starts at 341, loses 3 per cycle, and advances the count each time it reaches zero or goes below.

Software loads an 8-bit reload value four bits at a time. It then writes a 3-bit control word that picks the mode, sets the enable, and stores what the enable should become after an acknowledge. When the count passes 0xFF it reloads from the reload value and raises a level interrupt. That interrupt stays high until a control write or an acknowledge clears it. The count and the reload value are brought out for observation. Every strobe takes effect at the clock edge where it is sampled high, so its result shows on the outputs after that edge.

Top module: `irq_tick_timer`

## Requirements
- R1: After reset, the count, the reload value and the interrupt are all zero, and the timer is disabled.
- R2: A low-nibble write copies wr_data[3:0] into reload bits 3:0. A high-nibble write copies wr_data[3:0] into reload bits 7:4. The other nibble is kept in both cases.
- R3: A control write decodes wr_data[2] as cycle mode (1) or scanline mode (0), wr_data[1] as enable, and wr_data[0] as the enable-after-acknowledge value. It clears the interrupt and presets the prescaler to 341. If the enable bit is set, the count is loaded from the reload value.
- R4: A control write with the enable bit clear disables the timer and leaves the count unchanged.
- R5: An acknowledge clears the interrupt and sets the enable to the stored enable-after-acknowledge value.
- R6: While the timer is disabled, CPU strobes change neither the count nor the prescaler.
- R7: In cycle mode, each enabled CPU strobe advances the count once.
- R8: In scanline mode, each enabled CPU strobe subtracts 3 from the prescaler. When the result is 0 or below, 341 is added back and the count advances. The first advance after a control write therefore falls on the 114th strobe, and the next one 114 strobes later.
- R9: An advance increments the count. When the count is 0xFF, the advance instead reloads the reload value and raises the interrupt, which stays high until it is cleared.
- R10: A CPU strobe that arrives in the same cycle as a control write or an acknowledge is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_tick | input | 1 | One strobe per CPU cycle |
| wr_lat_lo | input | 1 | Write reload bits 3:0 from wr_data[3:0] |
| wr_lat_hi | input | 1 | Write reload bits 7:4 from wr_data[3:0] |
| wr_ctrl | input | 1 | Control write from wr_data[2:0] |
| ack | input | 1 | Acknowledge strobe |
| wr_data | input | 8 | Register write data |
| irq | output | 1 | Level interrupt request |
| cnt_q | output | 8 | Current count |
| lat_q | output | 8 | Current reload value |

## Verification
A wrong mode or enable bit shows on cnt_q one strobe after the first enabled CPU cycle. The count either fails to move in cycle mode or moves too early in scanline mode. A prescaler that is off by one step is hidden for about a hundred cycles and only shows as the 114th-strobe advance arriving one strobe early or late. A wrong wrap decision shows on irq and cnt_q at the edge that passes 0xFF. A wrong acknowledge value shows on the next CPU strobe, when the count either advances or stays still.

// File: rtl/irq_tick_pkg.sv
package irq_tick_pkg;
  localparam int PRE_W    = 10;
  localparam int PRE_INIT = 341;
  localparam int PRE_DEC  = 3;

  typedef logic signed [PRE_W-1:0] pre_t;

  // Replace one nibble of the reload value, keeping the other.
  function automatic logic [7:0] nib_merge(input logic [7:0] cur, input logic hi,
                                           input logic [3:0] d);
    return hi ? {d, cur[3:0]} : {cur[7:4], d};
  endfunction

  // Prescaler value after one subtraction step.
  function automatic pre_t pre_sub(input pre_t p);
    return p - pre_t'(PRE_DEC);
  endfunction

  // True when a subtracted value asks for an advance of the count.
  function automatic logic pre_hit(input pre_t d);
    return d <= pre_t'(0);
  endfunction
endpackage

// File: rtl/itt_latch.sv
module itt_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_lo,
  input  logic         wr_hi,
  input  logic [W/2-1:0] d,
  output logic [W-1:0] lat
);
  always_ff @(posedge clk) begin
    if (!rst_n)      lat <= '0;
    else if (wr_lo)  lat <= {lat[W-1:W/2], d};
    else if (wr_hi)  lat <= {d, lat[W/2-1:0]};
  end
endmodule

// File: rtl/itt_prescaler.sv
module itt_prescaler
  import irq_tick_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic step,
  output pre_t pre_q,
  output logic fire
);
  pre_t diff;
  always_comb begin
    diff = pre_sub(pre_q);
    fire = step && pre_hit(diff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      pre_q <= '0;
    else if (preset) pre_q <= pre_t'(PRE_INIT);
    else if (step)   pre_q <= fire ? diff + pre_t'(PRE_INIT) : diff;
  end
endmodule

// File: rtl/itt_counter.sv
module itt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         adv,
  input  logic         clr,
  input  logic [W-1:0] lat,
  output logic [W-1:0] cnt,
  output logic         pend,
  output logic         wrap
);
  localparam logic [W-1:0] TOP = '1;

  assign wrap = adv && (cnt == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= lat;
    else if (adv)   cnt <= wrap ? lat : cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     pend <= 1'b0;
    else if (clr)   pend <= 1'b0;
    else if (wrap)  pend <= 1'b1;
  end
endmodule

// File: rtl/irq_tick_timer.sv
module irq_tick_timer
  import irq_tick_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpu_tick,
  input  logic         wr_lat_lo,
  input  logic         wr_lat_hi,
  input  logic         wr_ctrl,
  input  logic         ack,
  input  logic [W-1:0] wr_data,
  output logic         irq,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] lat_q
);
  localparam int NW = W / 2;

  logic en_q, mode_q, ea_q;
  logic tick_ok, pre_step, pre_fire, cnt_adv, cnt_wrap;
  pre_t pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= 1'b0; ea_q <= 1'b0;
    end else if (wr_ctrl) begin
      mode_q <= wr_data[2];
      en_q   <= wr_data[1];
      ea_q   <= wr_data[0];
    end else if (ack) begin
      en_q   <= ea_q;
    end
  end

  // Named internal events
  assign tick_ok  = cpu_tick && en_q && !wr_ctrl && !ack;
  assign pre_step = tick_ok && !mode_q;
  assign cnt_adv  = tick_ok && (mode_q || pre_fire);

  itt_latch #(.W(W)) u_lat (
    .clk(clk), .rst_n(rst_n), .wr_lo(wr_lat_lo), .wr_hi(wr_lat_hi),
    .d(wr_data[NW-1:0]), .lat(lat_q)
  );

  itt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .preset(wr_ctrl), .step(pre_step),
    .pre_q(pre_q), .fire(pre_fire)
  );

  itt_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(wr_ctrl && wr_data[1]), .adv(cnt_adv),
    .clr(wr_ctrl || ack), .lat(lat_q), .cnt(cnt_q), .pend(irq), .wrap(cnt_wrap)
  );
endmodule

// File: rtl/itt_checker.sv
module itt_checker
  import irq_tick_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cpu_tick,
  input logic         wr_ctrl,
  input logic         ack,
  input logic         irq,
  input logic [W-1:0] cnt_q,
  input logic         en_q,
  input logic         mode_q,
  input pre_t         pre_q,
  input logic         cnt_wrap
);
  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(cnt_wrap));
  // R3
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> !irq);
  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !irq);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_ctrl) |=> ($stable(cnt_q) && $stable(pre_q)));
  // R7
  cycle_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && mode_q && cpu_tick && !wr_ctrl && !ack && cnt_q != '1)
      |=> cnt_q == $past(cnt_q) + 1'b1);
  // R8
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q > -pre_t'(PRE_DEC)) && (pre_q <= pre_t'(PRE_INIT)));
endmodule

bind irq_tick_timer itt_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_ctrl(wr_ctrl), .ack(ack),
  .irq(irq), .cnt_q(cnt_q), .en_q(en_q), .mode_q(mode_q), .pre_q(pre_q),
  .cnt_wrap(cnt_wrap)
);

// File: tb/irq_tick_timer_bench.sv
module irq_tick_timer_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_tick = 0, wr_lat_lo = 0, wr_lat_hi = 0, wr_ctrl = 0, ack = 0;
  logic [7:0] wr_data = '0;
  logic irq;
  logic [7:0] cnt_q, lat_q;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_tick_timer u_irq_tick_timer (
    .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .wr_lat_lo(wr_lat_lo),
    .wr_lat_hi(wr_lat_hi), .wr_ctrl(wr_ctrl), .ack(ack), .wr_data(wr_data),
    .irq(irq), .cnt_q(cnt_q), .lat_q(lat_q)
  );

  // ops: 0 lat lo, 1 lat hi, 2 ctrl, 3 ack, 4 tick
  // fields: op[31:28] data[27:20] cnt[19:12] lat[11:4] irq[0]
  localparam int NV = 18;
  localparam logic [31:0] VEC [NV] = '{
    {4'd0, 8'h0E, 8'h00, 8'h0E, 4'd0}, // R2
    {4'd1, 8'h0F, 8'h00, 8'hFE, 4'd0}, // R2
    {4'd2, 8'h06, 8'hFE, 8'hFE, 4'd0}, // R3
    {4'd4, 8'h00, 8'hFF, 8'hFE, 4'd0}, // R7
    {4'd4, 8'h00, 8'hFE, 8'hFE, 4'd1}, // R9
    {4'd3, 8'h00, 8'hFE, 8'hFE, 4'd0}, // R5
    {4'd4, 8'h00, 8'hFE, 8'hFE, 4'd0}, // R6
    {4'd2, 8'h07, 8'hFE, 8'hFE, 4'd0}, // R3
    {4'd4, 8'h00, 8'hFF, 8'hFE, 4'd0}, // R7
    {4'd4, 8'h00, 8'hFE, 8'hFE, 4'd1}, // R9
    {4'd3, 8'h00, 8'hFE, 8'hFE, 4'd0}, // R5
    {4'd4, 8'h00, 8'hFF, 8'hFE, 4'd0}, // R5
    {4'd0, 8'h03, 8'hFF, 8'hF3, 4'd0}, // R2
    {4'd4, 8'h00, 8'hF3, 8'hF3, 4'd1}, // R9
    {4'd2, 8'h00, 8'hF3, 8'hF3, 4'd0}, // R4
    {4'd4, 8'h00, 8'hF3, 8'hF3, 4'd0}, // R6
    {4'd1, 8'h02, 8'hF3, 8'h23, 4'd0}, // R2
    {4'd2, 8'h04, 8'hF3, 8'h23, 4'd0}  // R4
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic op(input int code, input logic [7:0] d, input bit with_tick = 0);
    @(negedge clk);
    wr_data   = d;
    wr_lat_lo = (code == 0);
    wr_lat_hi = (code == 1);
    wr_ctrl   = (code == 2);
    ack       = (code == 3);
    cpu_tick  = (code == 4) || with_tick;
    @(negedge clk);
    {wr_lat_lo, wr_lat_hi, wr_ctrl, ack, cpu_tick} = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) op(4, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 cnt", cnt_q, 8'h00);
    check("R1 lat", lat_q, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
    ticks(3);
    check("R1 disabled after reset", cnt_q, 8'h00);

    for (int v = 0; v < NV; v++) begin
      op(int'(VEC[v][31:28]), VEC[v][27:20]);
      check($sformatf("vec%0d cnt R7/R9", v), cnt_q, VEC[v][19:12]);
      check($sformatf("vec%0d lat R2", v), lat_q, VEC[v][11:4]);
      check($sformatf("vec%0d irq R5/R9", v), {7'd0, irq}, {7'd0, VEC[v][0]});
    end

    // R8 scanline mode: first advance on strobe 114, next after 114 more
    op(0, 8'h0E); op(1, 8'h0F);
    op(2, 8'h02);
    ticks(113);
    check("R8 before 114th", cnt_q, 8'hFE);
    ticks(1);
    check("R8 at 114th", cnt_q, 8'hFF);
    ticks(113);
    check("R8 second interval early", cnt_q, 8'hFF);
    check("R8 no irq yet", {7'd0, irq}, 8'h00);
    ticks(1);
    check("R8 second advance wraps R9", cnt_q, 8'hFE);
    check("R9 irq after wrap", {7'd0, irq}, 8'h01);

    // R10 strobe with control write is ignored; count loads the reload value
    op(2, 8'h06, 1);
    check("R10 ctrl+tick", cnt_q, 8'hFE);
    op(3, 8'h00, 1);
    check("R10 ack+tick", cnt_q, 8'hFE);
    check("R5 ack disables (ea=0)", {7'd0, irq}, 8'h00);
    ticks(2);
    check("R6 disabled after ack", cnt_q, 8'hFE);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule